// File: doc/BRIEF.md
# Maskable interrupt factor controller

This block collects the interrupt sources of a small 4-bit microcontroller and turns them into one interrupt request line for the CPU. It watches three clock-timer tap signals and two stopwatch tap signals. It also watches a group of four input pins and a single input pin. Each source has a sticky factor flag. A flag is set when its source condition occurs. It stays set until the CPU reads the register that holds it. The read returns the flag values and clears those flags in the same access.

The timer and stopwatch taps set their flags on a falling edge. The pin group uses a two-state machine. In state `GRP_MATCH` the enabled pins equal their comparison bits. In state `GRP_DIFF` at least one enabled pin differs from its comparison bit. The transition `GRP_MATCH -> GRP_DIFF` sets the group flag. The transition `GRP_DIFF -> GRP_MATCH` sets nothing. The single pin sets its flag on a rising edge or on a falling edge, selected by a control bit.

The interrupt request is raised only when three things hold at once: a flag is 1, the enable bit for that flag is 1, and the global enable input from the CPU is 1. All source inputs pass through a two-flop synchronizer before edge detection. Edges are found by comparing each synchronized value with a registered copy of its previous value. The CPU reaches the registers through a nibble-wide port with a read strobe and a write strobe.

Top module: `irq_factor_ctrl`

## Requirements
- R1: After reset, all flags, masks, comparison bits and the edge select bit are 0. Every register address reads 0, and `irq` is 0.
- R2: A falling edge on `tmr_tap[2]`, `tmr_tap[1]` or `tmr_tap[0]` sets bit 2, 1 or 0 of the timer flag register (address 0). A rising edge sets nothing. A set flag stays 1 until it is cleared by a read.
- R3: A falling edge on `sw_tap[1]` or `sw_tap[0]` sets bit 1 or 0 of the stopwatch flag register (address 1). A rising edge sets nothing.
- R4: Timer and stopwatch flags are set even when their mask bits are 0. The timer mask is at address 3, bits 2:0. The stopwatch mask is at address 4, bits 1:0.
- R5: Bit 0 of the port flag register (address 2) is set when the group moves from `GRP_MATCH` to `GRP_DIFF`. It is not set while the group stays in `GRP_DIFF`, and it is not set on a return to `GRP_MATCH`.
- R6: A group pin whose mask bit is 0 (address 5, bit i for `grp_pin[i]`) takes no part in the comparison with its comparison bit (address 6, bit i). When all mask bits are 0, the group counts as matching.
- R7: The single-pin control register is at address 7. Bit 0 is the pin enable and bit 1 is the edge select. With the enable at 1, the pin sets bit 1 of address 2 on a rising edge when the edge select is 0, and on a falling edge when the edge select is 1. With the enable at 0, the pin sets nothing.
- R8: A read of address 0, 1 or 2 (`rd_en` high) returns that register's flags on `rd_data` and clears them. A read of any other address leaves all flags unchanged.
- R9: If a flag's set event and a read-clear of that flag fall in the same cycle, the flag ends the cycle at 1.
- R10: `irq` is 1 exactly when `glb_en` is 1 and at least one flag is 1 together with its enable. The enables are: the matching timer or stopwatch mask bit; any group mask bit, for the group flag; the single-pin enable, for the single-pin flag.
- R11: Writes to addresses 0 to 2 have no effect. Addresses 3 to 7 read back the written value, with unused bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_tap | input | 3 | Clock-timer taps: bit 2 is 2 Hz, bit 1 is 8 Hz, bit 0 is 32 Hz |
| sw_tap | input | 2 | Stopwatch taps: bit 1 is 1 Hz, bit 0 is 10 Hz |
| grp_pin | input | 4 | Four-pin input group |
| edge_pin | input | 1 | Single edge-sensitive input pin |
| glb_en | input | 1 | Global interrupt enable from the CPU |
| rd_en | input | 1 | Register read strobe; clears flags at the addressed flag register |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wr_data | input | 4 | Write data |
| rd_data | output | 4 | Read data for `addr`; combinational |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
A source's set event and the CPU's read-clear of the same flag register can fall in the same cycle. The bench provokes this by holding the read strobe on the timer flag address for several consecutive cycles while a tap falls, so that one of those reads must coincide with the set. The bench judges the result in two steps. The event must show up as a 1 in at least one of the reads in that window. A single read after the window must then return 0, which shows that the event was delivered once and then cleared. The bench also drives the group pins and the mask and comparison registers together, to check that a register write that changes the match result counts as a group transition.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int REG_AW = 4;
    localparam logic [REG_AW-1:0] A_TMR_FLAG = 4'd0;
    localparam logic [REG_AW-1:0] A_SW_FLAG  = 4'd1;
    localparam logic [REG_AW-1:0] A_PRT_FLAG = 4'd2;
    localparam logic [REG_AW-1:0] A_TMR_MASK = 4'd3;
    localparam logic [REG_AW-1:0] A_SW_MASK  = 4'd4;
    localparam logic [REG_AW-1:0] A_GRP_MASK = 4'd5;
    localparam logic [REG_AW-1:0] A_GRP_CMP  = 4'd6;
    localparam logic [REG_AW-1:0] A_PIN_CTRL = 4'd7;

    typedef enum logic {
        GRP_MATCH = 1'b0,
        GRP_DIFF  = 1'b1
    } grp_state_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
            prev <= '0;
        end else begin
            meta <= d;
            q    <= meta;
            prev <= q;
        end
    end

    // R2
    prev_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> prev == $past(q));
endmodule

// File: rtl/irq_grp_fsm.sv
module irq_grp_fsm
    import irq_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins,
    input  logic [N-1:0] cmp,
    input  logic [N-1:0] mask,
    output logic         fire
);
    grp_state_t state, state_nx;
    logic       match;

    assign match = (((pins ^ cmp) & mask) == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= GRP_MATCH;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        fire     = 1'b0;
        unique case (state)
            GRP_MATCH: if (!match) begin
                state_nx = GRP_DIFF;
                fire     = 1'b1;
            end
            GRP_DIFF: if (match) state_nx = GRP_MATCH;
            default: state_nx = GRP_MATCH;
        endcase
    end

    // R5
    grp_fire_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> state == GRP_DIFF);
    // R5
    grp_no_refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic         clr,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= (clr ? '0 : q) | set;
    end

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((q & $past(set)) == $past(set)));
    // R8
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set == '0) |=> q == '0);
    // R2
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((q & $past(q)) == $past(q)));
endmodule

// File: rtl/irq_factor_ctrl.sv
module irq_factor_ctrl
    import irq_pkg::*;
#(
    parameter int TMR_N  = 3,
    parameter int SW_N   = 2,
    parameter int GRP_N  = 4,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMR_N-1:0]  tmr_tap,
    input  logic [SW_N-1:0]   sw_tap,
    input  logic [GRP_N-1:0]  grp_pin,
    input  logic              edge_pin,
    input  logic              glb_en,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    localparam int SRC_W = TMR_N + SW_N + GRP_N + 1;

    logic [SRC_W-1:0] s_cur, s_prev;
    logic [TMR_N-1:0] tmr_cur, tmr_prev, tmr_set, tmr_flag, tmr_mask;
    logic [SW_N-1:0]  sw_cur, sw_prev, sw_set, sw_flag, sw_mask;
    logic [GRP_N-1:0] grp_cur, grp_mask, grp_cmp;
    logic             pin_cur, pin_prev, pin_set, pin_en, pin_fall_sel;
    logic             grp_fire;
    logic [1:0]       prt_flag;

    irq_sync #(.W(SRC_W)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({tmr_tap, sw_tap, grp_pin, edge_pin}),
        .q(s_cur), .prev(s_prev)
    );

    assign {tmr_cur, sw_cur, grp_cur, pin_cur} = s_cur;
    assign tmr_prev = s_prev[SRC_W-1 -: TMR_N];
    assign sw_prev  = s_prev[SW_N+GRP_N -: SW_N];
    assign pin_prev = s_prev[0];

    assign tmr_set = tmr_prev & ~tmr_cur;
    assign sw_set  = sw_prev & ~sw_cur;
    assign pin_set = pin_en & (pin_fall_sel ? (pin_prev & ~pin_cur)
                                            : (~pin_prev & pin_cur));

    irq_grp_fsm #(.N(GRP_N)) u_grp (
        .clk(clk), .rst_n(rst_n),
        .pins(grp_cur), .cmp(grp_cmp), .mask(grp_mask),
        .fire(grp_fire)
    );

    irq_flag_reg #(.W(TMR_N)) u_tmr_flag (
        .clk(clk), .rst_n(rst_n), .set(tmr_set),
        .clr(rd_en && addr == A_TMR_FLAG), .q(tmr_flag)
    );
    irq_flag_reg #(.W(SW_N)) u_sw_flag (
        .clk(clk), .rst_n(rst_n), .set(sw_set),
        .clr(rd_en && addr == A_SW_FLAG), .q(sw_flag)
    );
    irq_flag_reg #(.W(2)) u_prt_flag (
        .clk(clk), .rst_n(rst_n), .set({pin_set, grp_fire}),
        .clr(rd_en && addr == A_PRT_FLAG), .q(prt_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_mask     <= '0;
            sw_mask      <= '0;
            grp_mask     <= '0;
            grp_cmp      <= '0;
            pin_en       <= 1'b0;
            pin_fall_sel <= 1'b0;
        end else if (wr_en) begin
            unique case (addr)
                A_TMR_MASK: tmr_mask <= wr_data[TMR_N-1:0];
                A_SW_MASK:  sw_mask  <= wr_data[SW_N-1:0];
                A_GRP_MASK: grp_mask <= wr_data[GRP_N-1:0];
                A_GRP_CMP:  grp_cmp  <= wr_data[GRP_N-1:0];
                A_PIN_CTRL: {pin_fall_sel, pin_en} <= wr_data[1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (addr)
            A_TMR_FLAG: rd_data = DATA_W'(tmr_flag);
            A_SW_FLAG:  rd_data = DATA_W'(sw_flag);
            A_PRT_FLAG: rd_data = DATA_W'(prt_flag);
            A_TMR_MASK: rd_data = DATA_W'(tmr_mask);
            A_SW_MASK:  rd_data = DATA_W'(sw_mask);
            A_GRP_MASK: rd_data = DATA_W'(grp_mask);
            A_GRP_CMP:  rd_data = DATA_W'(grp_cmp);
            A_PIN_CTRL: rd_data = DATA_W'({pin_fall_sel, pin_en});
            default:    rd_data = '0;
        endcase
    end

    assign irq = glb_en & ((|(tmr_flag & tmr_mask)) | (|(sw_flag & sw_mask)) |
                           (prt_flag[0] & (|grp_mask)) | (prt_flag[1] & pin_en));

    // R10
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |-> !irq);
    // R10
    irq_tmr_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en && (tmr_flag & tmr_mask) != '0) |-> irq);
    // R11
    flag_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && addr == A_TMR_FLAG && tmr_set == '0) |=> $stable(tmr_flag));
    // R7
    pin_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_en && !(rd_en && addr == A_PRT_FLAG)) |=> prt_flag[1] == $past(prt_flag[1]));
endmodule

// File: tb/test_irq_factor_ctrl.sv
module test_irq_factor_ctrl;
    localparam int CLK_P = 10;
    localparam int NV = 11;
    // {mask[12:9], cmp[8:5], pins[4:1], expected group flag[0]}
    localparam logic [12:0] VEC [NV] = '{
        {4'hF, 4'h0, 4'h0, 1'b0},
        {4'hF, 4'h0, 4'h1, 1'b1},
        {4'hF, 4'h0, 4'h3, 1'b0},
        {4'hF, 4'h0, 4'h0, 1'b0},
        {4'hE, 4'h0, 4'h1, 1'b0},
        {4'hE, 4'h0, 4'h9, 1'b1},
        {4'hE, 4'h9, 4'h9, 1'b0},
        {4'hE, 4'h9, 4'h8, 1'b0},
        {4'hE, 4'h9, 4'hC, 1'b1},
        {4'h0, 4'h9, 4'hC, 1'b0},
        {4'h0, 4'h9, 4'h5, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] tmr_tap = '0;
    logic [1:0] sw_tap = '0;
    logic [3:0] grp_pin = '0;
    logic       edge_pin = 1'b0;
    logic       glb_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [3:0] wr_data = '0;
    logic [3:0] rd_data;
    logic       irq;
    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    irq_factor_ctrl i_irq_factor_ctrl (
        .clk(clk), .rst_n(rst_n), .tmr_tap(tmr_tap), .sw_tap(sw_tap),
        .grp_pin(grp_pin), .edge_pin(edge_pin), .glb_en(glb_en),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk); #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [3:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(posedge clk); #1 rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
    endtask

    task automatic clear_all();
        logic [3:0] d;
        rd(4'd0, d); rd(4'd1, d); rd(4'd2, d);
    endtask

    initial begin
        logic [3:0] d;
        logic [3:0] seen;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(4'(a), d);
            check("R1 reset reg", d, 4'h0);
        end
        check("R1 reset irq", {3'b0, irq}, 4'h0);

        // R2 rising edges set nothing, falling edges set bits
        tmr_tap = 3'b111; settle();
        rd(4'd0, d); check("R2 rising no flag", d, 4'h0);
        tmr_tap = 3'b101; settle();
        rd(4'd0, d); check("R2 8Hz fall bit1", d, 4'h2);
        tmr_tap = 3'b000; settle();
        rd(4'd0, d); check("R2 2Hz+32Hz fall bits", d, 4'h5);
        rd(4'd0, d); check("R8 cleared after read", d, 4'h0);

        // R3 / R4 stopwatch falls with masks 0
        sw_tap = 2'b11; settle();
        rd(4'd1, d); check("R3 rising no flag", d, 4'h0);
        sw_tap = 2'b01; settle();
        rd(4'd1, d); check("R3 R4 1Hz fall masked", d, 4'h2);
        sw_tap = 2'b00; settle();
        rd(4'd1, d); check("R3 10Hz fall", d, 4'h1);

        // R8 read of a non-flag address leaves flags
        tmr_tap = 3'b100; settle(); tmr_tap = 3'b000; settle();
        rd(4'd3, d); rd(4'd1, d);
        rd(4'd0, d); check("R8 other reads keep flag", d, 4'h4);

        // R11 writes to flag regs ignored, mask regs read back
        wr(4'd0, 4'hF); wr(4'd1, 4'hF); wr(4'd2, 4'hF);
        rd(4'd0, d); check("R11 flag write tmr", d, 4'h0);
        rd(4'd1, d); check("R11 flag write sw", d, 4'h0);
        rd(4'd2, d); check("R11 flag write port", d, 4'h0);
        wr(4'd3, 4'hF); rd(4'd3, d); check("R11 tmr mask readback", d, 4'h7);
        wr(4'd4, 4'hF); rd(4'd4, d); check("R11 sw mask readback", d, 4'h3);
        wr(4'd7, 4'hE); rd(4'd7, d); check("R11 pin ctrl readback", d, 4'h2);
        wr(4'd3, 4'h0); wr(4'd4, 4'h0); wr(4'd7, 4'h0);

        // R10 interrupt gating
        glb_en = 1'b1;
        tmr_tap = 3'b010; settle(); tmr_tap = 3'b000; settle();
        #1 check("R10 flag masked no irq", {3'b0, irq}, 4'h0);
        wr(4'd3, 4'h2); #1 check("R10 enabled irq", {3'b0, irq}, 4'h1);
        glb_en = 1'b0; #1 check("R10 global off", {3'b0, irq}, 4'h0);
        glb_en = 1'b1; #1;
        rd(4'd0, d); #1 check("R10 irq drops on clear", {3'b0, irq}, 4'h0);
        wr(4'd3, 4'h0);
        sw_tap = 2'b01; settle(); sw_tap = 2'b00; settle();
        wr(4'd4, 4'h1); #1 check("R10 sw irq", {3'b0, irq}, 4'h1);
        rd(4'd1, d); wr(4'd4, 4'h0); glb_en = 1'b0;

        // R5 R6 group vectors
        for (int i = 0; i < NV; i++) begin
            wr(4'd6, VEC[i][8:5]);
            wr(4'd5, VEC[i][12:9]);
            grp_pin = VEC[i][4:1];
            settle();
            rd(4'd2, d);
            check($sformatf("R5 R6 group vector %0d", i), d, {3'b0, VEC[i][0]});
        end
        // R6 a register write that creates a mismatch counts
        wr(4'd5, 4'h4); settle();
        rd(4'd2, d); check("R6 mask write mismatch", d, 4'h1);
        glb_en = 1'b1; #1 check("R10 group irq after clear", {3'b0, irq}, 4'h0);
        glb_en = 1'b0;
        wr(4'd5, 4'h0); clear_all();

        // R7 single pin
        edge_pin = 1'b1; settle(); edge_pin = 1'b0; settle();
        rd(4'd2, d); check("R7 disabled pin", d, 4'h0);
        wr(4'd7, 4'h1);
        edge_pin = 1'b1; settle();
        rd(4'd2, d); check("R7 rising sel", d, 4'h2);
        edge_pin = 1'b0; settle();
        rd(4'd2, d); check("R7 falling ignored", d, 4'h0);
        wr(4'd7, 4'h3);
        edge_pin = 1'b1; settle();
        rd(4'd2, d); check("R7 rising ignored", d, 4'h0);
        edge_pin = 1'b0; settle();
        rd(4'd2, d); check("R7 falling sel", d, 4'h2);
        wr(4'd7, 4'h0);

        // R9 set and read-clear in one cycle
        tmr_tap = 3'b100; settle(); clear_all();
        seen = '0;
        @(negedge clk);
        addr = 4'd0; rd_en = 1'b1; tmr_tap = 3'b000;
        for (int c = 0; c < 8; c++) begin
            #1 seen = seen | rd_data;
            @(negedge clk);
        end
        rd_en = 1'b0;
        check("R9 event seen under reads", seen, 4'h4);
        rd(4'd0, d); check("R9 cleared once", d, 4'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule